// File: doc/BRIEF.md
# Micromirror Block Load Sequencer

This block sits on the host side of a micromirror display link and runs one block load followed by one mirror display cycle at a time. After reset it waits for the display controller to report that it is configured, and then that it is initialized. Until both have been seen it stays inert. Once both are seen it reports itself ready.

A single-cycle `go_i` starts a cycle and captures a block address and a block mode. The block address and mode stay on the outputs until the next cycle is accepted. The sequencer first sends the block control word, on channel 0 only, and waits for that channel's done handshake. It then asks every data channel to stream block data. Each channel's done pulse is held in a sticky bit.

When every channel has finished, the sequencer issues a one-cycle load request. It then waits for the controller's active-low busy flag to assert, and after that to release. A programmable timeout raises an error flag if the busy flag never asserts. After the busy flag releases, the sequencer waits until no mirror operation is in progress. It then issues a one-cycle pulse start and returns to idle.

Top module: `mm_load_seq`

## Requirements
- R1: After reset `ready_o` is low. The initialization input is ignored until the configuration input has been seen high. `ready_o` goes high only after both have been seen, configuration first.
- R2: `go_i` is accepted only while `ready_o` is high. `ready_o` is high when the sequencer is idle and initialized and `busy_n_i` is high. A `go_i` at any other time has no effect on any output.
- R3: After an accepted `go_i`, `ctrl_send_o` is high from the next cycle until the cycle in which `ctrl_done_i` is sampled high. While it is high, `data_send_o` is all zero. No control word request exists for channels 1 and above.
- R4: From the cycle after `ctrl_done_i` is captured, bit i of `data_send_o` is high until a high `data_done_i[i]` has been captured. The done bit stays remembered until the next accepted `go_i`.
- R5: `load_req_o` is high for exactly one cycle: the cycle after the last outstanding channel done has been captured. It is never high before every channel has finished.
- R6: After the load request, the sequencer waits for `busy_n_i` to be sampled low. If `busy_n_i` is not sampled low in the first `tmo_lim_i` cycles after the load-request cycle, `err_o` goes high in the following cycle. `err_o` stays high until the next accepted `go_i`. The limit must be at least 1.
- R7: After busy has been seen, or after a timeout, the sequencer waits for `busy_n_i` to be high before it may fire.
- R8: `pulse_start_o` is high for exactly one cycle. It is only ever high while `busy_n_i` is high and `pulse_active_i` is low. It is delayed for as long as `pulse_active_i` stays high. In the cycle after it, the sequencer is idle again.
- R9: `blk_addr_o` and `blk_mode_o` take the operands of an accepted `go_i` in the next cycle. They hold those values until the next accepted `go_i`.
- R10: In reset, all request outputs, `err_o` and `ready_o` are low, and `blk_addr_o` and `blk_mode_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done_i | input | 1 | Controller configuration complete |
| init_done_i | input | 1 | Controller initialization complete |
| busy_n_i | input | 1 | Controller block busy, active low |
| pulse_active_i | input | 1 | Mirror clocking pulse in progress |
| tmo_lim_i | input | TW | Busy-assert timeout in cycles (at least 1) |
| go_i | input | 1 | Start one load-and-display cycle |
| addr_i | input | AW | Block address operand |
| mode_i | input | MW | Block mode operand |
| ready_o | output | 1 | Idle, initialized and controller not busy |
| ctrl_send_o | output | 1 | Send block control word on channel 0 |
| ctrl_done_i | input | 1 | Channel 0 control word sent |
| data_send_o | output | NCH | Per-channel stream block data |
| data_done_i | input | NCH | Per-channel data transfer finished |
| blk_addr_o | output | AW | Held block address |
| blk_mode_o | output | MW | Held block mode |
| load_req_o | output | 1 | One-cycle load request |
| pulse_start_o | output | 1 | One-cycle mirror clocking pulse start |
| err_o | output | 1 | Busy flag never asserted within the limit |

## Verification
The bench builds the block with four channels, a 4-bit address and a 4-bit timeout limit. It sweeps timeout limits 2 and 3. For each limit it covers sixteen channel completion patterns, including simultaneous and scattered finishes. It also covers every busy onset from immediate to past the limit, two busy lengths, and pulse-active holds of zero and one cycle. This small setup makes the exact cycle of every load request, timeout, error flag and pulse start predictable by arithmetic. It also exercises refused `go_i` attempts during every non-idle phase.

// File: rtl/mm_seq_pkg.sv
package mm_seq_pkg;
  typedef enum logic [2:0] {
    ST_CFG   = 3'd0,
    ST_INIT  = 3'd1,
    ST_IDLE  = 3'd2,
    ST_CTRL  = 3'd3,
    ST_DATA  = 3'd4,
    ST_BWAIT = 3'd5,
    ST_BUSY  = 3'd6,
    ST_FIRE  = 3'd7
  } seq_state_e;
endpackage

// File: rtl/mm_chan_track.sv
module mm_chan_track #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  logic [NCH-1:0] done_i,
  output logic [NCH-1:0] sticky_o,
  output logic           all_done_o
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          sticky_o[g] <= 1'b0;
        else if (clr)
          sticky_o[g] <= 1'b0;
        else if (en && done_i[g])
          sticky_o[g] <= 1'b1;
      end
    end
  endgenerate

  assign all_done_o = &sticky_o;
endmodule

// File: rtl/mm_busy_timer.sv
module mm_busy_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] lim,
  output logic          expired_o
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)
      cnt_d = '0;
    else if (cnt_q != CNT_MAX)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign expired_o = en && (({1'b0, cnt_q} + 1'b1) == {1'b0, lim});
endmodule

// File: rtl/mm_seq_fsm.sv
module mm_seq_fsm
  import mm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_done_i,
  input  logic       init_done_i,
  input  logic       busy_n_i,
  input  logic       pulse_active_i,
  input  logic       go_i,
  input  logic       ctrl_done_i,
  input  logic       all_done_i,
  input  logic       expired_i,
  output seq_state_e state_o,
  output logic       ready_o,
  output logic       accept_o,
  output logic       ld_req_o,
  output logic       fire_o,
  output logic       set_err_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    accept_o  = 1'b0;
    ld_req_o  = 1'b0;
    fire_o    = 1'b0;
    set_err_o = 1'b0;
    ready_o   = (st_q == ST_IDLE) && busy_n_i;
    unique case (st_q)
      ST_CFG:   if (cfg_done_i) st_d = ST_INIT;
      ST_INIT:  if (init_done_i) st_d = ST_IDLE;
      ST_IDLE: begin
        if (go_i && busy_n_i) begin
          accept_o = 1'b1;
          st_d     = ST_CTRL;
        end
      end
      ST_CTRL:  if (ctrl_done_i) st_d = ST_DATA;
      ST_DATA: begin
        if (all_done_i) begin
          ld_req_o = 1'b1;
          st_d     = ST_BWAIT;
        end
      end
      ST_BWAIT: begin
        if (!busy_n_i)
          st_d = ST_BUSY;
        else if (expired_i) begin
          set_err_o = 1'b1;
          st_d      = ST_BUSY;
        end
      end
      ST_BUSY:  if (busy_n_i) st_d = ST_FIRE;
      ST_FIRE: begin
        if (busy_n_i && !pulse_active_i) begin
          fire_o = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default:  st_d = ST_CFG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= ST_CFG;
    else
      st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/mm_load_seq.sv
module mm_load_seq
  import mm_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int MW  = 2,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_done_i,
  input  logic           init_done_i,
  input  logic           busy_n_i,
  input  logic           pulse_active_i,
  input  logic [TW-1:0]  tmo_lim_i,
  input  logic           go_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [MW-1:0]  mode_i,
  output logic           ready_o,
  output logic           ctrl_send_o,
  input  logic           ctrl_done_i,
  output logic [NCH-1:0] data_send_o,
  input  logic [NCH-1:0] data_done_i,
  output logic [AW-1:0]  blk_addr_o,
  output logic [MW-1:0]  blk_mode_o,
  output logic           load_req_o,
  output logic           pulse_start_o,
  output logic           err_o
);
  seq_state_e     state;
  logic           accept, ld_req, fire, set_err;
  logic           all_done, expired;
  logic [NCH-1:0] sticky;
  logic [AW-1:0]  addr_q;
  logic [MW-1:0]  mode_q;
  logic           err_q;

  mm_seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_done_i     (cfg_done_i),
    .init_done_i    (init_done_i),
    .busy_n_i       (busy_n_i),
    .pulse_active_i (pulse_active_i),
    .go_i           (go_i),
    .ctrl_done_i    (ctrl_done_i),
    .all_done_i     (all_done),
    .expired_i      (expired),
    .state_o        (state),
    .ready_o        (ready_o),
    .accept_o       (accept),
    .ld_req_o       (ld_req),
    .fire_o         (fire),
    .set_err_o      (set_err)
  );

  mm_chan_track #(.NCH(NCH)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (accept),
    .en         (state == ST_DATA),
    .done_i     (data_done_i),
    .sticky_o   (sticky),
    .all_done_o (all_done)
  );

  mm_busy_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (state == ST_BWAIT),
    .lim       (tmo_lim_i),
    .expired_o (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= '0;
    end else if (accept) begin
      addr_q <= addr_i;
      mode_q <= mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (accept)
      err_q <= 1'b0;
    else if (set_err)
      err_q <= 1'b1;
  end

  assign ctrl_send_o   = (state == ST_CTRL);
  assign data_send_o   = (state == ST_DATA) ? ~sticky : '0;
  assign blk_addr_o    = addr_q;
  assign blk_mode_o    = mode_q;
  assign load_req_o    = ld_req;
  assign pulse_start_o = fire;
  assign err_o         = err_q;
endmodule

// File: rtl/mm_load_seq_chk.sv
module mm_load_seq_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int MW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy_n_i,
  input logic           pulse_active_i,
  input logic           go_i,
  input logic           ready_o,
  input logic           ctrl_send_o,
  input logic [NCH-1:0] data_send_o,
  input logic [AW-1:0]  blk_addr_o,
  input logic [MW-1:0]  blk_mode_o,
  input logic           load_req_o,
  input logic           pulse_start_o
);
  AST_CTRL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_send_o |-> (data_send_o == '0)); // R3
  AST_LREQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    load_req_o |=> !load_req_o); // R5
  AST_LREQ_NO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    load_req_o |-> (!ctrl_send_o && data_send_o == '0)); // R5
  AST_FIRE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start_o |-> (busy_n_i && !pulse_active_i)); // R8
  AST_FIRE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start_o |=> !pulse_start_o); // R8
  AST_OPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_i && ready_o) |=> ($stable(blk_addr_o) && $stable(blk_mode_o))); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (busy_n_i && !ctrl_send_o && !load_req_o)); // R2
endmodule

bind mm_load_seq mm_load_seq_chk #(.NCH(NCH), .AW(AW), .MW(MW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy_n_i       (busy_n_i),
  .pulse_active_i (pulse_active_i),
  .go_i           (go_i),
  .ready_o        (ready_o),
  .ctrl_send_o    (ctrl_send_o),
  .data_send_o    (data_send_o),
  .blk_addr_o     (blk_addr_o),
  .blk_mode_o     (blk_mode_o),
  .load_req_o     (load_req_o),
  .pulse_start_o  (pulse_start_o)
);

// File: tb/mm_load_seq_tb.sv
module mm_load_seq_tb;
  localparam int NCH = 4;
  localparam int AW  = 4;
  localparam int MW  = 2;
  localparam int TW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_done_i = 1'b0, init_done_i = 1'b0, busy_n_i = 1'b1, pulse_active_i = 1'b0;
  logic [TW-1:0] tmo_lim_i = 4'd2;
  logic go_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [MW-1:0] mode_i = '0;
  logic ctrl_done_i = 1'b0;
  logic [NCH-1:0] data_done_i = '0;
  logic ready_o, ctrl_send_o, load_req_o, pulse_start_o, err_o;
  logic [NCH-1:0] data_send_o;
  logic [AW-1:0] blk_addr_o;
  logic [MW-1:0] blk_mode_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mm_load_seq #(.NCH(NCH), .AW(AW), .MW(MW), .TW(TW)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_block(input int lim, input int p, input int bd, input int bl, input int pa);
    int dd[NCH];
    logic [AW-1:0] a;
    logic [MW-1:0] m;
    bit tmo;
    int fk, ek;
    a = AW'(p + lim * 5 + bd);
    m = MW'(p + bl + pa);
    for (int i = 0; i < NCH; i++)
      dd[i] = (i == p % 4) ? 3 : ((p * i + p / 4) % 4);
    tmo = (bd >= lim);
    tmo_lim_i = TW'(lim);
    @(negedge clk);
    #1 check(ready_o == 1'b1, "R2 ready before go", ready_o, 1);
    go_i = 1'b1; addr_i = a; mode_i = m;
    @(negedge clk);
    go_i = 1'b0; addr_i = ~a; mode_i = ~m;
    #1;
    check(ctrl_send_o == 1'b1, "R3 ctrl send", ctrl_send_o, 1);
    check(data_send_o == '0, "R3 no data during ctrl", data_send_o, 0);
    check(blk_addr_o == a && blk_mode_o == m, "R9 operands latched", blk_addr_o, a);
    check(err_o == 1'b0, "R6 err cleared by go", err_o, 0);
    for (int c = 0; c < p % 3; c++) begin
      @(negedge clk);
      #1 check(ctrl_send_o == 1'b1 && ready_o == 1'b0, "R3 ctrl held", ctrl_send_o, 1);
    end
    @(negedge clk);
    ctrl_done_i = 1'b1;
    #1 check(data_send_o == '0, "R4 no data before ctrl done", data_send_o, 0);
    for (int j = 0; j < 4; j++) begin
      logic [NCH-1:0] exp_s;
      @(negedge clk);
      ctrl_done_i = 1'b0;
      for (int i = 0; i < NCH; i++) begin
        data_done_i[i] = (dd[i] == j);
        exp_s[i] = (dd[i] >= j);
      end
      #1;
      check(data_send_o == exp_s, "R4 per-channel send", data_send_o, exp_s);
      check(ctrl_send_o == 1'b0, "R3 ctrl released", ctrl_send_o, 0);
      check(load_req_o == 1'b0, "R5 no early load req", load_req_o, 0);
    end
    @(negedge clk);
    data_done_i = '0;
    #1 check(load_req_o == 1'b1, "R5 load req after last done", load_req_o, 1);
    fk = tmo ? lim + 1 : bd + bl + 1;
    ek = fk + pa;
    for (int k = 0; k <= ek + 1; k++) begin
      @(negedge clk);
      busy_n_i = !(!tmo && k >= bd && k < bd + bl);
      pulse_active_i = (k < fk + pa);
      go_i = (k <= ek);
      addr_i = ~a; mode_i = ~m;
      #1;
      check(pulse_start_o == (k == ek), "R8 pulse start timing", pulse_start_o, (k == ek));
      check(load_req_o == 1'b0, "R5 single load req", load_req_o, 0);
      check(ctrl_send_o == 1'b0, "R2 no ctrl word while busy", ctrl_send_o, 0);
      check(err_o == (tmo && k >= lim), "R6 timeout flag", err_o, (tmo && k >= lim));
      check(blk_addr_o == a && blk_mode_o == m, "R9 operands held", blk_addr_o, a);
      check(ready_o == (k == ek + 1), "R7 ready after fire", ready_o, (k == ek + 1));
    end
    go_i = 1'b0;
    pulse_active_i = 1'b0;
  endtask

  initial begin
    #(5 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    check(ready_o == 0 && ctrl_send_o == 0 && load_req_o == 0 && pulse_start_o == 0 && err_o == 0,
          "R10 reset outputs", ready_o, 0);
    check(blk_addr_o == 0 && blk_mode_o == 0 && data_send_o == 0, "R10 reset operands", blk_addr_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    init_done_i = 1'b1;
    go_i = 1'b1; addr_i = 4'hA;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      #1 check(ready_o == 0 && ctrl_send_o == 0, "R1 init ignored before cfg", ready_o, 0);
    end
    go_i = 1'b0;
    init_done_i = 1'b0;
    cfg_done_i = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1 check(ready_o == 0, "R1 wait for init", ready_o, 0);
    end
    init_done_i = 1'b1;
    @(negedge clk);
    #1 check(ready_o == 1, "R1 ready after cfg then init", ready_o, 1);
    check(blk_addr_o == 0, "R2 early go ignored", blk_addr_o, 0);
    busy_n_i = 1'b0;
    go_i = 1'b1; addr_i = 4'h5;
    @(negedge clk);
    #1 check(ready_o == 0 && ctrl_send_o == 0 && blk_addr_o == 0, "R2 go ignored while busy", ctrl_send_o, 0);
    go_i = 1'b0;
    busy_n_i = 1'b1;
    for (int lim = 2; lim <= 3; lim++)
      for (int p = 0; p < 16; p++)
        for (int bd = 0; bd <= lim; bd++)
          for (int bl = 1; bl <= 2; bl++)
            for (int pa = 0; pa <= 1; pa++)
              run_block(lim, p, bd, bl, pa);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule